// File: doc/BRIEF.md
# Progressive Soft-Sensing Read Sequencer

This block steps a single page read through up to two sensing passes of rising precision. A read is first served by a coarse hard-decision sense that places every cell in one of four threshold regions. That result goes to an external decoder. A finer nonuniform soft sense, which places every cell in one of seven regions, is requested only when the decoder reports failure on the coarse data. The cheap pass therefore carries most reads, and the slow pass is paid only when it is needed.

The second sense returns only a small zone offset for each cell, not a full region index. The sequencer keeps the coarse regions from the first pass and combines them with those offsets to produce the full soft region of each cell before the second decode.

The read request and the sense command are valid/ready channels. A request is taken only in a cycle where `req_ready` is high, and the requester must hold `req_valid` and `req_page` until then. The sense command is raised as `sense_valid` and held with a stable level and page until `sense_ready` is seen. The sensing side may stall it for any number of cycles. Sense completion, decoder start and decoder verdicts are plain pulses.

Top module: `psr_read_seq`

## Requirements
- R1: After reset, req_ready is 1 and sense_valid, dec_start, read_done, read_fail, step_cnt and read_step are all 0.
- R2: A request is taken on a cycle with req_valid and req_ready both high. From the next cycle req_ready stays 0 until the cycle after read_done or read_fail. Requests offered meanwhile have no effect.
- R3: The cycle after a request is taken, sense_valid rises with sense_level 0 (hard) and sense_page equal to the requested page. Both stay stable until sense_ready is seen. step_cnt is cleared when a request is taken and grows by one for each sense command accepted.
- R4: A sense_done pulse that arrives before the pending sense command has been accepted is ignored.
- R5: In the cycle after a sense_done for the hard pass, dec_start is high for exactly one cycle with dec_level 0. Field i of dec_data is bits [3i+2:3i] and carries the coarse region {0, sense_data[2i+1:2i]}.
- R6: dec_pass and dec_fail count only in cycles after the dec_start cycle. If both are high together, pass wins.
- R7: A pass on the hard pass gives read_done in the next cycle with read_step 1, and no soft sense command is issued.
- R8: A fail on the hard pass raises a soft sense command (sense_level 1, same page) in the next cycle.
- R9: For the soft decode, dec_level is 1 and field i of dec_data is built from the retained coarse region h of cell i and the offset code o = sense_data[2i+1:2i] of the soft sense. Code 01 gives 2h-1 (0 when h is 0). Code 10 gives 2h+1 (6 when h is 3). Codes 00 and 11 give 2h.
- R10: A pass on the soft decode gives read_done with read_step 2. A fail gives read_fail with read_step 0, and the sequencer returns to idle.
- R11: read_done and read_fail are never high together, each lasts one cycle, and req_ready is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_page | input | PAGE_W | Page address of the request |
| sense_valid | output | 1 | Sense command pending |
| sense_ready | input | 1 | Sensing side accepts the command |
| sense_level | output | 1 | 0 = coarse hard sense, 1 = fine soft sense |
| sense_page | output | PAGE_W | Page to sense |
| sense_done | input | 1 | Sense finished, sense_data valid this cycle |
| sense_data | input | 2*CELLS | Hard regions (pass 1) or zone offsets (pass 2) |
| dec_start | output | 1 | One-cycle decoder start |
| dec_level | output | 1 | Precision of the data offered to the decoder |
| dec_data | output | 3*CELLS | Per-cell region index for the decoder |
| dec_pass | input | 1 | Decoder success pulse |
| dec_fail | input | 1 | Decoder failure pulse |
| read_done | output | 1 | Read finished successfully (pulse) |
| read_fail | output | 1 | Read failed after both passes (pulse) |
| read_step | output | 2 | Pass that produced the successful decode |
| step_cnt | output | 2 | Sense commands accepted in the current read |

## Verification
Every result has a fixed latency, and each check samples exactly there:
- A sense command appears one cycle after the request is taken.
- step_cnt moves one cycle after the command handshake.
- dec_start and dec_data appear one cycle after sense_done.
- read_done, read_fail or the soft command appears one cycle after the decoder verdict.
- req_ready returns one cycle after that.

Inputs are driven and outputs sampled at the falling edge, so every check looks at the cycle that the count of registers along the path predicts. Random reads cover mixed pass/fail outcomes, stalls and latencies. Directed reads cover clamping at both region edges, early decoder verdicts, simultaneous pass and fail, stray sense_done pulses and requests offered while busy.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int HARD_REGIONS = 4;
  localparam int SOFT_REGIONS = 7;
  localparam int HR_W  = $clog2(HARD_REGIONS);
  localparam int SR_W  = $clog2(SOFT_REGIONS);
  localparam int OFF_W = 2;

  localparam logic [OFF_W-1:0] OFF_LOW  = 2'b01;
  localparam logic [OFF_W-1:0] OFF_HIGH = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SENSE_HARD,
    ST_DEC_HARD,
    ST_SENSE_SOFT,
    ST_DEC_SOFT,
    ST_DONE
  } psr_state_e;
endpackage

// File: rtl/psr_step_fsm.sv
module psr_step_fsm
  import psr_pkg::*;
#(
  parameter int PAGE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PAGE_W-1:0] req_page,
  output logic              req_ready,
  output logic              sense_valid,
  input  logic              sense_ready,
  output logic              sense_level,
  output logic [PAGE_W-1:0] sense_page,
  input  logic              sense_done,
  output logic              dec_start,
  output logic              dec_level,
  input  logic              dec_pass,
  input  logic              dec_fail,
  output logic              read_done,
  output logic              read_fail,
  output logic [1:0]        read_step,
  output logic [1:0]        step_cnt,
  output logic              cap_hard,
  output logic              cap_soft
);
  psr_state_e        state;
  logic              issued;
  logic              started;
  logic              fail_q;
  logic [PAGE_W-1:0] page_q;
  logic [1:0]        steps_q;
  logic [1:0]        res_step_q;

  logic in_sense, in_dec, cmd_fire, sense_end, verdict_ok;

  // Decoded views of the state register.
  always_comb begin
    in_sense   = (state == ST_SENSE_HARD) || (state == ST_SENSE_SOFT);
    in_dec     = (state == ST_DEC_HARD) || (state == ST_DEC_SOFT);
    cmd_fire   = sense_valid && sense_ready;
    sense_end  = in_sense && issued && sense_done;
    verdict_ok = in_dec && started;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      issued     <= 1'b0;
      started    <= 1'b0;
      fail_q     <= 1'b0;
      page_q     <= '0;
      steps_q    <= '0;
      res_step_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            page_q  <= req_page;
            steps_q <= '0;
            issued  <= 1'b0;
            state   <= ST_SENSE_HARD;
          end
        end
        ST_SENSE_HARD, ST_SENSE_SOFT: begin
          if (cmd_fire) begin
            issued  <= 1'b1;
            steps_q <= steps_q + 2'd1;
          end
          if (sense_end) begin
            issued  <= 1'b0;
            started <= 1'b0;
            state   <= (state == ST_SENSE_HARD) ? ST_DEC_HARD : ST_DEC_SOFT;
          end
        end
        ST_DEC_HARD, ST_DEC_SOFT: begin
          if (!started) begin
            started <= 1'b1;
          end else if (dec_pass) begin
            res_step_q <= (state == ST_DEC_HARD) ? 2'd1 : 2'd2;
            fail_q     <= 1'b0;
            state      <= ST_DONE;
          end else if (dec_fail) begin
            if (state == ST_DEC_HARD) begin
              state <= ST_SENSE_SOFT;
            end else begin
              res_step_q <= 2'd0;
              fail_q     <= 1'b1;
              state      <= ST_DONE;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready   = (state == ST_IDLE);
    sense_valid = in_sense && !issued;
    sense_level = (state == ST_SENSE_SOFT);
    sense_page  = page_q;
    dec_start   = in_dec && !started;
    dec_level   = (state == ST_DEC_SOFT);
    read_done   = (state == ST_DONE) && !fail_q;
    read_fail   = (state == ST_DONE) && fail_q;
    read_step   = res_step_q;
    step_cnt    = steps_q;
    cap_hard    = sense_end && (state == ST_SENSE_HARD);
    cap_soft    = sense_end && (state == ST_SENSE_SOFT);
  end

  // The verdict qualifier is kept as a named signal for readability.
  logic unused_ok;
  assign unused_ok = verdict_ok;
endmodule

// File: rtl/psr_coarse_store.sv
module psr_coarse_store
  import psr_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_hard,
  input  logic                   cap_soft,
  input  logic [CELLS*HR_W-1:0]  sense_data,
  output logic [CELLS*HR_W-1:0]  hard_regions,
  output logic [CELLS*OFF_W-1:0] soft_offsets
);
  // Coarse regions survive the whole soft pass; offsets overwrite only on pass two.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hard_regions <= '0;
      soft_offsets <= '0;
    end else begin
      if (cap_hard) hard_regions <= sense_data;
      if (cap_soft) soft_offsets <= sense_data;
    end
  end
endmodule

// File: rtl/psr_region_merge.sv
module psr_region_merge
  import psr_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic [CELLS*HR_W-1:0]  hard_regions,
  input  logic [CELLS*OFF_W-1:0] soft_offsets,
  input  logic                   use_soft,
  output logic [CELLS*SR_W-1:0]  regions
);
  localparam logic [HR_W-1:0] H_TOP = HR_W'(HARD_REGIONS - 1);
  localparam logic [SR_W-1:0] S_TOP = SR_W'(SOFT_REGIONS - 1);

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic [HR_W-1:0]  h;
    logic [OFF_W-1:0] o;
    logic [SR_W-1:0]  center, fine, coarse;

    always_comb begin
      h      = hard_regions[i*HR_W +: HR_W];
      o      = soft_offsets[i*OFF_W +: OFF_W];
      center = {h, 1'b0};
      coarse = SR_W'(h);
      if (o == OFF_LOW)
        fine = (h == '0) ? '0 : center - SR_W'(1);
      else if (o == OFF_HIGH)
        fine = (h == H_TOP) ? S_TOP : center + SR_W'(1);
      else
        fine = center;
      regions[i*SR_W +: SR_W] = use_soft ? fine : coarse;
    end
  end
endmodule

// File: rtl/psr_read_seq.sv
module psr_read_seq
  import psr_pkg::*;
#(
  parameter int CELLS  = 4,
  parameter int PAGE_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [PAGE_W-1:0]     req_page,
  output logic                  sense_valid,
  input  logic                  sense_ready,
  output logic                  sense_level,
  output logic [PAGE_W-1:0]     sense_page,
  input  logic                  sense_done,
  input  logic [CELLS*2-1:0]    sense_data,
  output logic                  dec_start,
  output logic                  dec_level,
  output logic [CELLS*3-1:0]    dec_data,
  input  logic                  dec_pass,
  input  logic                  dec_fail,
  output logic                  read_done,
  output logic                  read_fail,
  output logic [1:0]            read_step,
  output logic [1:0]            step_cnt
);
  localparam int HW = CELLS * HR_W;
  localparam int OW = CELLS * OFF_W;

  logic          cap_hard, cap_soft;
  logic [HW-1:0] hard_regions;
  logic [OW-1:0] soft_offsets;

  psr_step_fsm #(.PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_page(req_page), .req_ready(req_ready),
    .sense_valid(sense_valid), .sense_ready(sense_ready),
    .sense_level(sense_level), .sense_page(sense_page),
    .sense_done(sense_done),
    .dec_start(dec_start), .dec_level(dec_level),
    .dec_pass(dec_pass), .dec_fail(dec_fail),
    .read_done(read_done), .read_fail(read_fail),
    .read_step(read_step), .step_cnt(step_cnt),
    .cap_hard(cap_hard), .cap_soft(cap_soft)
  );

  psr_coarse_store #(.CELLS(CELLS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cap_hard(cap_hard), .cap_soft(cap_soft),
    .sense_data(sense_data),
    .hard_regions(hard_regions), .soft_offsets(soft_offsets)
  );

  psr_region_merge #(.CELLS(CELLS)) u_merge (
    .hard_regions(hard_regions), .soft_offsets(soft_offsets),
    .use_soft(dec_level), .regions(dec_data)
  );
endmodule

// File: rtl/psr_read_seq_chk.sv
module psr_read_seq_chk #(
  parameter int PAGE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              sense_valid,
  input logic              sense_ready,
  input logic              sense_level,
  input logic [PAGE_W-1:0] sense_page,
  input logic              dec_start,
  input logic              read_done,
  input logic              read_fail,
  input logic [1:0]        read_step,
  input logic [1:0]        step_cnt
);
  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_hold_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sense_valid && !sense_ready |=> sense_valid && $stable(sense_level) && $stable(sense_page));

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_start |=> !dec_start);

  p_soft_after_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sense_valid && sense_level |-> step_cnt == 2'd1);

  p_done_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    read_done |-> (read_step == 2'd1 || read_step == 2'd2));

  p_fail_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    read_fail |-> read_step == 2'd0);

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(read_done && read_fail));

  p_end_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    read_done || read_fail |=> !read_done && !read_fail && req_ready);
endmodule

bind psr_read_seq psr_read_seq_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .sense_valid(sense_valid), .sense_ready(sense_ready),
  .sense_level(sense_level), .sense_page(sense_page),
  .dec_start(dec_start), .read_done(read_done), .read_fail(read_fail),
  .read_step(read_step), .step_cnt(step_cnt)
);

// File: tb/psr_read_seq_bench.sv
module psr_read_seq_bench;
  localparam int CELLS  = 4;
  localparam int PAGE_W = 12;
  localparam int DW = CELLS * 2;
  localparam int RW = CELLS * 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [PAGE_W-1:0] req_page = '0;
  logic              sense_valid;
  logic              sense_ready = 1'b0;
  logic              sense_level;
  logic [PAGE_W-1:0] sense_page;
  logic              sense_done = 1'b0;
  logic [DW-1:0]     sense_data = '0;
  logic              dec_start;
  logic              dec_level;
  logic [RW-1:0]     dec_data;
  logic              dec_pass = 1'b0;
  logic              dec_fail = 1'b0;
  logic              read_done;
  logic              read_fail;
  logic [1:0]        read_step;
  logic [1:0]        step_cnt;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  psr_read_seq #(.CELLS(CELLS), .PAGE_W(PAGE_W)) u_psr_read_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .sense_valid(sense_valid), .sense_ready(sense_ready),
    .sense_level(sense_level), .sense_page(sense_page), .sense_done(sense_done),
    .sense_data(sense_data), .dec_start(dec_start), .dec_level(dec_level),
    .dec_data(dec_data), .dec_pass(dec_pass), .dec_fail(dec_fail),
    .read_done(read_done), .read_fail(read_fail), .read_step(read_step),
    .step_cnt(step_cnt)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [RW-1:0] exp_hard(input logic [DW-1:0] hd);
    logic [RW-1:0] r;
    for (int i = 0; i < CELLS; i++) r[3*i +: 3] = {1'b0, hd[2*i +: 2]};
    return r;
  endfunction

  function automatic logic [RW-1:0] exp_soft(input logic [DW-1:0] hd, input logic [DW-1:0] so);
    logic [RW-1:0] r;
    for (int i = 0; i < CELLS; i++) begin
      int h;
      int v;
      h = int'(hd[2*i +: 2]);
      case (so[2*i +: 2])
        2'b01:   v = (h == 0) ? 0 : 2*h - 1;
        2'b10:   v = (h == 3) ? 6 : 2*h + 1;
        default: v = 2*h;
      endcase
      r[3*i +: 3] = 3'(v);
    end
    return r;
  endfunction

  task automatic do_read(input logic [PAGE_W-1:0] page, input logic [DW-1:0] hd,
                         input bit hpass, input logic [DW-1:0] so, input bit spass,
                         input bit stray, input bit early, input bit both);
    chk(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    req_page  = page;
    cyc();
    chk(req_ready == 1'b0, "R2 busy after accept", int'(req_ready), 0);
    chk(sense_valid && !sense_level, "R3 hard command raised", int'({sense_valid, sense_level}), 2);
    chk(sense_page == page, "R3 command page", int'(sense_page), int'(page));
    chk(step_cnt == 2'd0, "R3 step count cleared", int'(step_cnt), 0);
    if (stray) begin
      req_page   = ~page;
      sense_done = 1'b1;
      sense_data = ~hd;
      cyc();
      sense_done = 1'b0;
      chk(sense_valid == 1'b1, "R4 stray done ignored", int'(sense_valid), 1);
      chk(dec_start == 1'b0, "R4 no decode on stray done", int'(dec_start), 0);
      chk(sense_page == page, "R2 busy request ignored", int'(sense_page), int'(page));
    end
    req_valid = 1'b0;
    repeat ($urandom % 3) begin
      cyc();
      chk(sense_valid && !sense_level, "R3 command held under stall", int'(sense_valid), 1);
    end
    sense_ready = 1'b1;
    cyc();
    sense_ready = 1'b0;
    chk(sense_valid == 1'b0, "R3 command dropped after accept", int'(sense_valid), 0);
    chk(step_cnt == 2'd1, "R3 step count one", int'(step_cnt), 1);
    repeat ($urandom % 4) begin
      cyc();
      chk(dec_start == 1'b0, "R5 no early decode", int'(dec_start), 0);
    end
    sense_done = 1'b1;
    sense_data = hd;
    cyc();
    sense_done = 1'b0;
    sense_data = '0;
    chk(dec_start && !dec_level, "R5 hard decode start", int'({dec_start, dec_level}), 2);
    chk(dec_data == exp_hard(hd), "R5 hard dec data", int'(dec_data), int'(exp_hard(hd)));
    if (early) dec_pass = 1'b1;
    cyc();
    dec_pass = 1'b0;
    chk(dec_start == 1'b0, "R5 start is one cycle", int'(dec_start), 0);
    if (early) chk(read_done == 1'b0, "R6 verdict in start cycle ignored", int'(read_done), 0);
    repeat ($urandom % 3) cyc();
    if (hpass) begin
      dec_pass = 1'b1;
      dec_fail = both;
      cyc();
      dec_pass = 1'b0;
      dec_fail = 1'b0;
      chk(read_done && !read_fail, "R7 done after hard pass", int'({read_done, read_fail}), 2);
      if (both) chk(read_done == 1'b1, "R6 pass wins over fail", int'(read_done), 1);
      chk(read_step == 2'd1, "R7 step one reported", int'(read_step), 1);
      chk(sense_valid == 1'b0, "R7 no soft command", int'(sense_valid), 0);
      cyc();
      chk(req_ready && !read_done, "R11 one-cycle done then ready", int'({req_ready, read_done}), 2);
      return;
    end
    dec_fail = 1'b1;
    cyc();
    dec_fail = 1'b0;
    chk(sense_valid && sense_level, "R8 soft command after fail", int'({sense_valid, sense_level}), 3);
    chk(sense_page == page, "R8 soft command page", int'(sense_page), int'(page));
    sense_ready = 1'b1;
    cyc();
    sense_ready = 1'b0;
    chk(step_cnt == 2'd2, "R3 step count two", int'(step_cnt), 2);
    repeat ($urandom % 3) cyc();
    sense_done = 1'b1;
    sense_data = so;
    cyc();
    sense_done = 1'b0;
    sense_data = '0;
    chk(dec_start && dec_level, "R9 soft decode start", int'({dec_start, dec_level}), 3);
    chk(dec_data == exp_soft(hd, so), "R9 merged soft data", int'(dec_data), int'(exp_soft(hd, so)));
    cyc();
    if (spass) dec_pass = 1'b1;
    else dec_fail = 1'b1;
    cyc();
    dec_pass = 1'b0;
    dec_fail = 1'b0;
    if (spass) begin
      chk(read_done && !read_fail, "R10 done after soft pass", int'({read_done, read_fail}), 2);
      chk(read_step == 2'd2, "R10 step two reported", int'(read_step), 2);
    end else begin
      chk(read_fail && !read_done, "R10 fail after soft fail", int'({read_done, read_fail}), 1);
      chk(read_step == 2'd0, "R10 step cleared on fail", int'(read_step), 0);
    end
    cyc();
    chk(req_ready && !read_done && !read_fail, "R11 end pulse then ready",
        int'({req_ready, read_done, read_fail}), 4);
  endtask

  initial begin
    void'($urandom(32'd20135));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    chk(!sense_valid && !dec_start, "R1 reset no command", int'({sense_valid, dec_start}), 0);
    chk(!read_done && !read_fail, "R1 reset no end", int'({read_done, read_fail}), 0);
    chk(step_cnt == 0 && read_step == 0, "R1 reset counters", int'({step_cnt, read_step}), 0);
    rst_n = 1'b1;
    cyc();
    // Directed corner cases.
    do_read(12'h0A5, 8'h00, 1'b0, 8'h55, 1'b1, 1'b0, 1'b0, 1'b0); // low clamp
    do_read(12'h3C3, 8'hFF, 1'b0, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0); // high clamp
    do_read(12'h111, 8'hE4, 1'b0, 8'h1B, 1'b1, 1'b1, 1'b0, 1'b0); // mixed, stray done
    do_read(12'h222, 8'h39, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1); // early and both
    for (int k = 0; k < 40; k++) begin
      do_read(PAGE_W'($urandom), DW'($urandom), 1'($urandom), DW'($urandom),
              1'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0),
              1'($urandom % 4 == 0));
      repeat ($urandom % 3) cyc();
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule